// File: doc/BRIEF.md
# Keyboard-Controller Port Logic with A20 Gate

This block is the host-facing side of a legacy keyboard controller, kept only for the part of its job that still matters at boot: gating address line 20 and raising a system reset. The host reaches it through two byte locations on a simple read/write bus. One location is for data and the other is for commands and status. A status byte tells software when it may write and when a byte is waiting to be read. A short command set turns the keyboard flag on and off, runs a self-test, and reads or writes the controller's 8-bit output port.

Each accepted write is held in an input holding register. A small sequencer then processes it over a fixed number of busy cycles. Bit 1 of the output port drives the A20 enable. That enable also masks bit 20 of a 32-bit address passing through the block. A write that clears bit 0 of the output port produces a low-going reset pulse of programmable length.

The sequencer has three states. ST_IDLE takes the transition "accept" to ST_BUSY when a write hits either location. ST_BUSY takes the transition "count done" to ST_EXEC when its countdown reaches zero. ST_EXEC takes the transition "retire" back to ST_IDLE after one cycle, and the byte's effect is applied in that cycle.

Top module: `kbc_a20_ctrl`

## Requirements
- R1: Reading location 0x60 returns the output buffer and reading 0x64 returns the status byte. Any other location reads 0x00, and writes to any other location change nothing.
- R2: The status byte is laid out as follows: bit 0 output-buffer-full, bit 1 input-busy, bit 2 system flag, bit 3 last accepted write (1 = command at 0x64, 0 = data at 0x60), bit 4 keyboard enabled, bits 7..5 zero.
- R3: After reset the status reads 0x10, the output port holds 0x01, `a20_en` is 0 and `sys_reset_n` is 1.
- R4: After the clock edge that accepts a write, input-busy reads 1 for exactly BUSY_CYCLES+1 cycles. The write's effect appears on the edge that clears input-busy.
- R5: A write that arrives while input-busy is 1 is dropped. It has no effect and does not change status bit 3.
- R6: Command 0xAD clears the keyboard-enabled flag and command 0xAE sets it.
- R7: Command 0xD0 copies the output port into the output buffer and sets output-buffer-full. A read of 0x60 clears output-buffer-full.
- R8: A data write loads the output port only when the command accepted just before it was 0xD1. Any other command issued in between cancels that pending load. Data writes without a pending load leave the port unchanged.
- R9: `a20_en` equals bit 1 of the output port.
- R10: A port load whose bit 0 is 0 drives `sys_reset_n` low for exactly RST_PULSE cycles. Bit 0 of the port still reads back as 1. A load with bit 0 set gives no pulse.
- R11: Command 0xAA places 0x55 in the output buffer, sets output-buffer-full and sets the system flag.
- R12: `mem_addr_out` equals `mem_addr_in`, except that bit 20 is forced to 0 while `a20_en` is 0.
- R13: An unlisted command code changes nothing except status bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus select; reads return 0 when low |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe; a read of 0x60 clears output-buffer-full |
| bus_addr | input | 8 | Byte location (0x60 data, 0x64 command/status) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| a20_en | output | 1 | Address line 20 enable (output port bit 1) |
| sys_reset_n | output | 1 | Active-low system reset pulse |
| mem_addr_in | input | ADDR_W | Address to be gated |
| mem_addr_out | output | ADDR_W | Gated address |

## Verification
The main function is driven by a table of command sequences. The table separates commands sent to the right location from those sent to the wrong one. It also separates data writes that were armed by 0xD1 from unarmed writes and from writes whose arming was cancelled, and it separates ordinary output-buffer reads from self-test reads. Status reads after each step confirm that bits 3 and 4 change only on the writes that should move them. Directed cases count the exact busy window, drop a write that arrives while busy, measure the reset pulse against a port load that leaves bit 0 set, and apply all-ones and single-bit addresses to the mask with the gate open and with it closed.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BUSY,
        ST_EXEC
    } seq_state_t;

    localparam logic [7:0] CMD_KB_OFF   = 8'hAD;
    localparam logic [7:0] CMD_KB_ON    = 8'hAE;
    localparam logic [7:0] CMD_PORT_RD  = 8'hD0;
    localparam logic [7:0] CMD_PORT_WR  = 8'hD1;
    localparam logic [7:0] CMD_SELFTEST = 8'hAA;
    localparam logic [7:0] SELFTEST_OK  = 8'h55;
    localparam logic [7:0] PORT_RESET   = 8'h01;

    localparam int SB_OBF  = 0;
    localparam int SB_IBF  = 1;
    localparam int SB_SYS  = 2;
    localparam int SB_CMD  = 3;
    localparam int SB_KBEN = 4;

    localparam int PB_RESET = 0;
    localparam int PB_GATE  = 1;

    typedef struct packed {
        logic kb_off;
        logic kb_on;
        logic port_read;
        logic port_load;
        logic self_test;
    } kbc_act_t;

endpackage

// File: rtl/kbc_seq.sv
module kbc_seq
    import kbc_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb,
    input  logic       wr_is_cmd,
    input  logic [7:0] wr_byte,
    output logic       accept,
    output logic       busy,
    output kbc_act_t   act,
    output logic [7:0] act_byte
);

    localparam int CW = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES);
    localparam logic [CW-1:0] CNT_LOAD = CW'(BUSY_CYCLES - 1);

    seq_state_t    state, nxt;
    logic [CW-1:0] cnt;
    logic [7:0]    held_byte;
    logic          held_cmd;
    logic          armed;

    assign accept = wr_stb && (state == ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // holding register, countdown and pending port load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            held_byte <= '0;
            held_cmd  <= 1'b0;
            armed     <= 1'b0;
        end else begin
            if (accept) begin
                held_byte <= wr_byte;
                held_cmd  <= wr_is_cmd;
                cnt       <= CNT_LOAD;
            end else if (state == ST_BUSY && cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
            if (state == ST_EXEC) begin
                armed <= held_cmd && (held_byte == CMD_PORT_WR);
            end
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (wr_stb) nxt = ST_BUSY;
            ST_BUSY: if (cnt == '0) nxt = ST_EXEC;
            ST_EXEC: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        act      = '0;
        act_byte = held_byte;
        busy     = (state != ST_IDLE);
        if (state == ST_EXEC) begin
            if (held_cmd) begin
                case (held_byte)
                    CMD_KB_OFF:   act.kb_off    = 1'b1;
                    CMD_KB_ON:    act.kb_on     = 1'b1;
                    CMD_PORT_RD:  act.port_read = 1'b1;
                    CMD_SELFTEST: act.self_test = 1'b1;
                    default:      act           = '0;
                endcase
            end else begin
                act.port_load = armed;
            end
        end
    end

endmodule

// File: rtl/kbc_outport.sv
module kbc_outport
    import kbc_pkg::*;
#(
    parameter int RST_PULSE = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_byte,
    output logic [7:0] port_q,
    output logic       sys_reset_n
);

    localparam int RW = $clog2(RST_PULSE + 1);
    localparam logic [RW-1:0] PULSE_LOAD = RW'(RST_PULSE);

    logic [RW-1:0] rst_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q  <= PORT_RESET;
            rst_cnt <= '0;
        end else begin
            if (load) begin
                port_q           <= load_byte;
                port_q[PB_RESET] <= 1'b1;
            end
            if (load && !load_byte[PB_RESET]) begin
                rst_cnt <= PULSE_LOAD;
            end else if (rst_cnt != '0) begin
                rst_cnt <= rst_cnt - 1'b1;
            end
        end
    end

    assign sys_reset_n = (rst_cnt == '0);

endmodule

// File: rtl/kbc_a20_mask.sv
module kbc_a20_mask #(
    parameter int ADDR_W   = 32,
    parameter int GATE_BIT = 20
) (
    input  logic              gate_en,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        if (i == GATE_BIT) begin : g_gated
            assign addr_out[i] = addr_in[i] & gate_en;
        end else begin : g_pass
            assign addr_out[i] = addr_in[i];
        end
    end

endmodule

// File: rtl/kbc_a20_ctrl.sv
module kbc_a20_ctrl
    import kbc_pkg::*;
#(
    parameter int         BUSY_CYCLES = 4,
    parameter int         RST_PULSE   = 8,
    parameter int         ADDR_W      = 32,
    parameter int         GATE_BIT    = 20,
    parameter logic [7:0] DATA_LOC    = 8'h60,
    parameter logic [7:0] CTRL_LOC    = 8'h64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              a20_en,
    output logic              sys_reset_n,
    input  logic [ADDR_W-1:0] mem_addr_in,
    output logic [ADDR_W-1:0] mem_addr_out
);

    logic       hit_data, hit_ctrl, wr_hit, rd_data_hit;
    logic       accept, ibf;
    kbc_act_t   act;
    logic [7:0] act_byte;
    logic [7:0] port_q;
    logic [7:0] obuf;
    logic       obf, sys_flag, kb_en, last_cmd;
    logic       obuf_load;
    logic [7:0] status;

    assign hit_data    = bus_sel && (bus_addr == DATA_LOC);
    assign hit_ctrl    = bus_sel && (bus_addr == CTRL_LOC);
    assign wr_hit      = bus_wr && (hit_data || hit_ctrl);
    assign rd_data_hit = bus_rd && hit_data;
    assign obuf_load   = act.port_read || act.self_test;

    kbc_seq #(.BUSY_CYCLES(BUSY_CYCLES)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_hit),
        .wr_is_cmd(hit_ctrl),
        .wr_byte  (bus_wdata),
        .accept   (accept),
        .busy     (ibf),
        .act      (act),
        .act_byte (act_byte)
    );

    kbc_outport #(.RST_PULSE(RST_PULSE)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (act.port_load),
        .load_byte  (act_byte),
        .port_q     (port_q),
        .sys_reset_n(sys_reset_n)
    );

    assign a20_en = port_q[PB_GATE];

    kbc_a20_mask #(.ADDR_W(ADDR_W), .GATE_BIT(GATE_BIT)) u_mask (
        .gate_en (a20_en),
        .addr_in (mem_addr_in),
        .addr_out(mem_addr_out)
    );

    // controller flags and output buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            obuf     <= '0;
            obf      <= 1'b0;
            sys_flag <= 1'b0;
            kb_en    <= 1'b1;
            last_cmd <= 1'b0;
        end else begin
            if (accept) last_cmd <= hit_ctrl;
            if (act.kb_off) kb_en <= 1'b0;
            if (act.kb_on)  kb_en <= 1'b1;
            if (act.port_read) begin
                obuf <= port_q;
                obf  <= 1'b1;
            end else if (act.self_test) begin
                obuf     <= SELFTEST_OK;
                obf      <= 1'b1;
                sys_flag <= 1'b1;
            end else if (rd_data_hit) begin
                obf <= 1'b0;
            end
        end
    end

    always_comb begin
        status          = '0;
        status[SB_OBF]  = obf;
        status[SB_IBF]  = ibf;
        status[SB_SYS]  = sys_flag;
        status[SB_CMD]  = last_cmd;
        status[SB_KBEN] = kb_en;
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_data)      bus_rdata = obuf;
        else if (hit_ctrl) bus_rdata = status;
    end

endmodule

// File: rtl/kbc_a20_ctrl_chk.sv
module kbc_a20_ctrl_chk #(
    parameter int ADDR_W   = 32,
    parameter int GATE_BIT = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              accept,
    input logic              ibf,
    input logic              wr_hit,
    input logic              last_cmd,
    input logic              obf,
    input logic              rd_data_hit,
    input logic              obuf_load,
    input logic              port_load,
    input logic              a20_en,
    input logic              sys_reset_n,
    input logic [ADDR_W-1:0] mem_addr_in,
    input logic [ADDR_W-1:0] mem_addr_out
);

    localparam logic [ADDR_W-1:0] KEEP = ~(ADDR_W'(1) << GATE_BIT);

    // R4
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ibf) |-> $past(accept));

    // R5
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ibf && wr_hit) |=> $stable(last_cmd));

    // R7
    obf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_hit && !obuf_load) |=> !obf);

    // R9
    gate_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(a20_en) |-> $past(port_load));

    // R10
    reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_reset_n) |-> $past(port_load));

    // R12
    mask_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_addr_out ^ mem_addr_in) & KEEP) == '0);

    // R12
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !a20_en |-> !mem_addr_out[GATE_BIT]);

endmodule

bind kbc_a20_ctrl kbc_a20_ctrl_chk #(.ADDR_W(ADDR_W), .GATE_BIT(GATE_BIT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .ibf         (ibf),
    .wr_hit      (wr_hit),
    .last_cmd    (last_cmd),
    .obf         (obf),
    .rd_data_hit (rd_data_hit),
    .obuf_load   (obuf_load),
    .port_load   (act.port_load),
    .a20_en      (a20_en),
    .sys_reset_n (sys_reset_n),
    .mem_addr_in (mem_addr_in),
    .mem_addr_out(mem_addr_out)
);

// File: tb/kbc_a20_ctrl_tb.sv
module kbc_a20_ctrl_tb_top;

    localparam int BUSY = 4;
    localparam int RPUL = 8;
    localparam int NV   = 34;

    // {op, location, data, expected, requirement}; op 0 write+wait, 1 read, 2 a20
    localparam logic [39:0] VEC [0:NV-1] = '{
        {8'd0, 8'h00, 8'h00, 8'h00, 8'd3},  // R3 placeholder: no-op write to 0x00
        {8'd1, 8'h64, 8'h00, 8'h10, 8'd2},  // R2 reset status
        {8'd0, 8'h64, 8'hD0, 8'h00, 8'd7},  // R7 read port
        {8'd1, 8'h64, 8'h00, 8'h19, 8'd7},  // R7 obf set
        {8'd1, 8'h60, 8'h00, 8'h01, 8'd7},  // R7 port value
        {8'd1, 8'h64, 8'h00, 8'h18, 8'd7},  // R7 obf cleared
        {8'd0, 8'h64, 8'hAD, 8'h00, 8'd6},  // R6 kb off
        {8'd1, 8'h64, 8'h00, 8'h08, 8'd6},
        {8'd0, 8'h64, 8'hAE, 8'h00, 8'd6},  // R6 kb on
        {8'd1, 8'h64, 8'h00, 8'h18, 8'd6},
        {8'd0, 8'h60, 8'h03, 8'h00, 8'd8},  // R8 unarmed data
        {8'd1, 8'h64, 8'h00, 8'h10, 8'd2},  // R2 bit3 = data
        {8'd2, 8'h00, 8'h00, 8'h00, 8'd8},  // R8 port untouched
        {8'd0, 8'h64, 8'hD1, 8'h00, 8'd8},
        {8'd0, 8'h60, 8'h03, 8'h00, 8'd8},  // R8 armed load
        {8'd2, 8'h00, 8'h00, 8'h01, 8'd9},  // R9 gate open
        {8'd0, 8'h64, 8'hD0, 8'h00, 8'd8},
        {8'd1, 8'h60, 8'h00, 8'h03, 8'd8},
        {8'd0, 8'h64, 8'hD1, 8'h00, 8'd8},
        {8'd0, 8'h64, 8'hAE, 8'h00, 8'd8},  // R8 cancel
        {8'd0, 8'h60, 8'h01, 8'h00, 8'd8},
        {8'd2, 8'h00, 8'h00, 8'h01, 8'd8},
        {8'd0, 8'h64, 8'h12, 8'h00, 8'd13}, // R13 unknown
        {8'd1, 8'h64, 8'h00, 8'h18, 8'd13},
        {8'd0, 8'h64, 8'hAA, 8'h00, 8'd11}, // R11 self-test
        {8'd1, 8'h64, 8'h00, 8'h1D, 8'd11},
        {8'd1, 8'h60, 8'h00, 8'h55, 8'd11},
        {8'd0, 8'h70, 8'hAD, 8'h00, 8'd1},  // R1 foreign location
        {8'd1, 8'h64, 8'h00, 8'h1C, 8'd1},
        {8'd1, 8'h70, 8'h00, 8'h00, 8'd1},
        {8'd0, 8'h64, 8'hD1, 8'h00, 8'd9},
        {8'd0, 8'h60, 8'h01, 8'h00, 8'd9},
        {8'd2, 8'h00, 8'h00, 8'h00, 8'd9},  // R9 gate closed
        {8'd1, 8'h64, 8'h00, 8'h14, 8'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0, bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        a20_en, sys_reset_n;
    logic [31:0] mem_addr_in = '0;
    logic [31:0] mem_addr_out;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    kbc_a20_ctrl #(.BUSY_CYCLES(BUSY), .RST_PULSE(RPUL)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .a20_en(a20_en), .sys_reset_n(sys_reset_n),
        .mem_addr_in(mem_addr_in), .mem_addr_out(mem_addr_out)
    );

    task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic peek_status(output logic [7:0] v);
        bus_sel  = 1'b1;
        bus_rd   = 1'b0;
        bus_addr = 8'h64;
        #2 v = bus_rdata;
    endtask

    task automatic raw_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int k = 0; k < 1000; k++) begin
            peek_status(s);
            if (!s[1]) break;
            @(negedge clk);
        end
    endtask

    task automatic write_wait(input logic [7:0] a, input logic [7:0] d);
        raw_write(a, d);
        wait_idle();
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #2 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R4 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 reset state
        check(3, {31'b0, a20_en}, 32'h0);
        check(3, {31'b0, sys_reset_n}, 32'h1);
        peek_status(v);
        check(3, {24'b0, v}, 32'h10);

        for (int i = 0; i < NV; i++) begin
            logic [7:0] op, a, d, e, r;
            {op, a, d, e, r} = VEC[i];
            if (op == 8'd0) begin
                write_wait(a, d);
            end else if (op == 8'd1) begin
                bus_read(a, v);
                check(int'(r), {24'b0, v}, {24'b0, e});
            end else begin
                @(negedge clk);
                check(int'(r), {31'b0, a20_en}, {31'b0, e[0]});
            end
        end

        // R4 busy window length
        raw_write(8'h64, 8'h12);
        n = 0;
        for (int k = 0; k < 100; k++) begin
            peek_status(v);
            if (!v[1]) break;
            n++;
            @(negedge clk);
        end
        check(4, n, BUSY + 1);

        // R5 write during busy is dropped
        raw_write(8'h64, 8'hAD);
        raw_write(8'h60, 8'h00);
        wait_idle();
        peek_status(v);
        check(5, {24'b0, v}, 32'h0C);
        write_wait(8'h64, 8'hAE);
        peek_status(v);
        check(5, {24'b0, v}, 32'h1C);

        // R10 reset pulse length and bit 0 read-back
        write_wait(8'h64, 8'hD1);
        raw_write(8'h60, 8'h02);
        n = 0;
        for (int k = 0; k < 40; k++) begin
            #2 if (!sys_reset_n) n++;
            @(negedge clk);
        end
        check(10, n, RPUL);
        check(9, {31'b0, a20_en}, 32'h1);
        write_wait(8'h64, 8'hD0);
        bus_read(8'h60, v);
        check(10, {24'b0, v}, 32'h03);

        // R12 mask, gate open
        mem_addr_in = 32'hFFFF_FFFF;
        #2 check(12, mem_addr_out, 32'hFFFF_FFFF);

        // R10 load with bit 0 set gives no pulse; closes gate for R12
        write_wait(8'h64, 8'hD1);
        raw_write(8'h60, 8'h01);
        n = 0;
        for (int k = 0; k < 30; k++) begin
            #2 if (!sys_reset_n) n++;
            @(negedge clk);
        end
        check(10, n, 0);
        #2 check(12, mem_addr_out, 32'hFFEF_FFFF);
        mem_addr_in = 32'h0010_0000;
        #2 check(12, mem_addr_out, 32'h0);
        mem_addr_in = 32'h0000_1234;
        #2 check(12, mem_addr_out, 32'h0000_1234);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule